// File: doc/BRIEF.md
# Dual-Port RAM with Cross-Port Mailbox Interrupts

This block is a synchronous memory shared by two agents, a left port and a right port. Each side can read or write any word on every clock edge. Each port has an active-low chip enable, an active-low write enable, an active-low output enable, an address, write data and registered read data. The default depth is 2048 words of 18 bits. The address width is a parameter, so setting it to 13 gives 8192 words.

The two highest addresses also serve as a doorbell between the agents. When one port writes the other port's mailbox word, the other port's active-low interrupt output goes low. The interrupt returns high when the receiving port reads that word. The mailbox words are still ordinary storage. Each port has an active-low busy input that stands in for an external arbiter. While a port's busy input is low, its mailbox accesses do not change the interrupt flags.

Top module: `dpm_mailbox_ram`

## Requirements
- R1: After reset, both interrupt outputs are high and both read-data outputs are zero.
- R2: A port writes when chip enable and write enable are both low. It reads when chip enable and output enable are low and write enable is high. Read data for a read appears on the data output one cycle later.
- R3: While a port is not reading, its data output keeps its last value.
- R4: A left-port write to the top address (all ones) with left busy high drives the right interrupt low on the next cycle.
- R5: A right-port read of the top address with right busy high drives the right interrupt high on the next cycle.
- R6: A right-port write to the address one below the top, with right busy high, drives the left interrupt low on the next cycle.
- R7: A left-port read of the address one below the top, with left busy high, drives the left interrupt high on the next cycle.
- R8: A mailbox access from a port whose busy input is low leaves both interrupt flags unchanged. The write data is still stored.
- R9: The following leave both flags unchanged: a port writing its own mailbox address (left to top-1, right to top), a read of the opposite port's mailbox, and any other access.
- R10: When a set and a clear of the same flag happen on the same edge, the flag ends up set (interrupt low).
- R11: The mailbox words store write data and return it on reads like any other word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous active-low reset |
| lCeN | input | 1 | Left chip enable, active low |
| lWeN | input | 1 | Left write enable, active low |
| lOeN | input | 1 | Left output enable, active low |
| lAddr | input | ADDR_W | Left word address |
| lDin | input | DATA_W | Left write data |
| lBusyN | input | 1 | Left busy from arbiter, active low |
| lDout | output | DATA_W | Left registered read data |
| lIntN | output | 1 | Left interrupt, active low |
| rCeN | input | 1 | Right chip enable, active low |
| rWeN | input | 1 | Right write enable, active low |
| rOeN | input | 1 | Right output enable, active low |
| rAddr | input | ADDR_W | Right word address |
| rDin | input | DATA_W | Right write data |
| rBusyN | input | 1 | Right busy from arbiter, active low |
| rDout | output | DATA_W | Right registered read data |
| rIntN | output | 1 | Right interrupt, active low |

## Verification
A wrong flag state appears on the interrupt pin one cycle after the edge that corrupted it, and it stays wrong until the next qualifying set or clear. The bench therefore compares both interrupt pins against its own flag model after every cycle. A corrupted array word stays hidden until a port reads that word. Random traffic is confined to a small pool of addresses that includes both mailboxes, so every stored word is read back within a few dozen cycles. A bad read path or a bad hold behaviour shows on the data output in the very next cycle.

// File: rtl/dpm_pkg.sv
package dpm_pkg;
  typedef struct packed {
    logic lWr;
    logic lRd;
    logic rWr;
    logic rRd;
  } dpStrobeT;
endpackage

// File: rtl/dpm_ctrl.sv
module dpm_ctrl
  import dpm_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [1:0]             ceN,
  input  logic [1:0]             weN,
  input  logic [1:0]             oeN,
  input  logic [1:0]             busyN,
  input  logic [1:0][ADDR_W-1:0] addr,
  output dpStrobeT               strobe,
  output logic [1:0]             intN
);
  localparam logic [ADDR_W-1:0] TOP_ADDR  = {ADDR_W{1'b1}};
  localparam logic [ADDR_W-1:0] TOPM_ADDR = TOP_ADDR - 1'b1;

  logic [1:0] wr, rd, setFlag, clrFlag, flag;

  for (genvar g = 0; g < 2; g++) begin : g_port
    localparam int OTHER = 1 - g;
    // Index 0 is the left port, whose inbox is top-1; the right port's inbox is top.
    localparam logic [ADDR_W-1:0] INBOX = (g == 0) ? TOPM_ADDR : TOP_ADDR;

    assign wr[g] = !ceN[g] && !weN[g];
    assign rd[g] = !ceN[g] && weN[g] && !oeN[g];
    assign setFlag[g] = wr[OTHER] && (addr[OTHER] == INBOX) && busyN[OTHER];
    assign clrFlag[g] = rd[g] && (addr[g] == INBOX) && busyN[g];

    always_ff @(posedge clk) begin
      if (!rstN)             flag[g] <= 1'b0;
      else if (setFlag[g])   flag[g] <= 1'b1;
      else if (clrFlag[g])   flag[g] <= 1'b0;
    end

    assign intN[g] = ~flag[g];

    // R4 R6: a cross write to the inbox raises this port's interrupt
    a_r4_cross_set: assert property (@(posedge clk) disable iff (!rstN)
      (!ceN[OTHER] && !weN[OTHER] && addr[OTHER] == INBOX && busyN[OTHER]) |=> !intN[g]);
    // R5 R7: an own read of the inbox clears it unless a set coincides
    a_r5_own_clear: assert property (@(posedge clk) disable iff (!rstN)
      (!ceN[g] && weN[g] && !oeN[g] && addr[g] == INBOX && busyN[g] &&
       !(!ceN[OTHER] && !weN[OTHER] && addr[OTHER] == INBOX && busyN[OTHER])) |=> intN[g]);
    // R8: this port busy and no cross set means the flag holds
    a_r8_busy_hold: assert property (@(posedge clk) disable iff (!rstN)
      (!busyN[g] && !(!ceN[OTHER] && !weN[OTHER] && addr[OTHER] == INBOX && busyN[OTHER]))
      |=> $stable(intN[g]));
    // R9: accesses touching no inbox leave the flag alone
    a_r9_no_mailbox: assert property (@(posedge clk) disable iff (!rstN)
      (addr[g] != INBOX && addr[OTHER] != INBOX) |=> $stable(intN[g]));
  end

  assign strobe.lWr = wr[0];
  assign strobe.lRd = rd[0];
  assign strobe.rWr = wr[1];
  assign strobe.rRd = rd[1];
endmodule

// File: rtl/dpm_datapath.sv
module dpm_datapath
  import dpm_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 18
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobeT          strobe,
  input  logic [ADDR_W-1:0] lAddr,
  input  logic [DATA_W-1:0] lDin,
  input  logic [ADDR_W-1:0] rAddr,
  input  logic [DATA_W-1:0] rDin,
  output logic [DATA_W-1:0] lDout,
  output logic [DATA_W-1:0] rDout
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (strobe.lWr) mem[lAddr] <= lDin;
    if (strobe.rWr) mem[rAddr] <= rDin;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lDout <= '0;
      rDout <= '0;
    end else begin
      if (strobe.lRd) lDout <= mem[lAddr];
      if (strobe.rRd) rDout <= mem[rAddr];
    end
  end

  // R3: outputs hold while their port does not read
  a_r3_left_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.lRd |=> $stable(lDout));
  a_r3_right_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.rRd |=> $stable(rDout));
endmodule

// File: rtl/dpm_mailbox_ram.sv
module dpm_mailbox_ram
  import dpm_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 18
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lCeN,
  input  logic              lWeN,
  input  logic              lOeN,
  input  logic [ADDR_W-1:0] lAddr,
  input  logic [DATA_W-1:0] lDin,
  input  logic              lBusyN,
  output logic [DATA_W-1:0] lDout,
  output logic              lIntN,
  input  logic              rCeN,
  input  logic              rWeN,
  input  logic              rOeN,
  input  logic [ADDR_W-1:0] rAddr,
  input  logic [DATA_W-1:0] rDin,
  input  logic              rBusyN,
  output logic [DATA_W-1:0] rDout,
  output logic              rIntN
);
  dpStrobeT   strobe;
  logic [1:0] intN;

  dpm_ctrl #(.ADDR_W(ADDR_W)) i_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .ceN    ({rCeN, lCeN}),
    .weN    ({rWeN, lWeN}),
    .oeN    ({rOeN, lOeN}),
    .busyN  ({rBusyN, lBusyN}),
    .addr   ({rAddr, lAddr}),
    .strobe (strobe),
    .intN   (intN)
  );

  dpm_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_data (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .lAddr  (lAddr),
    .lDin   (lDin),
    .rAddr  (rAddr),
    .rDin   (rDin),
    .lDout  (lDout),
    .rDout  (rDout)
  );

  assign lIntN = intN[0];
  assign rIntN = intN[1];
endmodule

// File: tb/test_dpm_mailbox_ram.sv
`timescale 1ns/1ps
module test_dpm_mailbox_ram;
  localparam int AW = 11;
  localparam int DW = 18;
  localparam logic [AW-1:0] TOP  = {AW{1'b1}};
  localparam logic [AW-1:0] TOPM = TOP - 1'b1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic lCeN = 1, lWeN = 1, lOeN = 1, lBusyN = 1;
  logic rCeN = 1, rWeN = 1, rOeN = 1, rBusyN = 1;
  logic [AW-1:0] lAddr = '0, rAddr = '0;
  logic [DW-1:0] lDin = '0, rDin = '0;
  logic [DW-1:0] lDout, rDout;
  logic lIntN, rIntN;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  logic [DW-1:0] mdl [0:(1<<AW)-1];
  logic [DW-1:0] expL = '0, expR = '0;
  logic flagL = 0, flagR = 0;

  always #2.5 clk = ~clk;

  dpm_mailbox_ram #(.ADDR_W(AW), .DATA_W(DW)) i_dpm_mailbox_ram (
    .clk(clk), .rstN(rstN),
    .lCeN(lCeN), .lWeN(lWeN), .lOeN(lOeN), .lAddr(lAddr), .lDin(lDin),
    .lBusyN(lBusyN), .lDout(lDout), .lIntN(lIntN),
    .rCeN(rCeN), .rWeN(rWeN), .rOeN(rOeN), .rAddr(rAddr), .rDin(rDin),
    .rBusyN(rBusyN), .rDout(rDout), .rIntN(rIntN)
  );

  function automatic logic nextFlag(logic cur, logic set, logic clr);
    return set ? 1'b1 : (clr ? 1'b0 : cur);
  endfunction

  task automatic chk(string tag, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic setL(logic ce, logic we, logic oe, logic [AW-1:0] a, logic [DW-1:0] d, logic b);
    lCeN = ce; lWeN = we; lOeN = oe; lAddr = a; lDin = d; lBusyN = b;
  endtask

  task automatic setR(logic ce, logic we, logic oe, logic [AW-1:0] a, logic [DW-1:0] d, logic b);
    rCeN = ce; rWeN = we; rOeN = oe; rAddr = a; rDin = d; rBusyN = b;
  endtask

  // One clock: model the edge from the driven inputs, then check at the falling edge.
  task automatic step();
    logic lw, lr, rw, rr, sL, cL, sR, cR, bL, bR;
    string tL, tR, dL, dR;
    @(posedge clk);
    lw = !lCeN && !lWeN; lr = !lCeN && lWeN && !lOeN;
    rw = !rCeN && !rWeN; rr = !rCeN && rWeN && !rOeN;
    dL = lr ? ((lAddr >= TOPM) ? "R11" : "R2") : "R3";
    dR = rr ? ((rAddr >= TOPM) ? "R11" : "R2") : "R3";
    if (lr) expL = mdl[lAddr];
    if (rr) expR = mdl[rAddr];
    sL = rw && rAddr == TOPM && rBusyN;  cL = lr && lAddr == TOPM && lBusyN;
    sR = lw && lAddr == TOP  && lBusyN;  cR = rr && rAddr == TOP  && rBusyN;
    bL = (rw && rAddr == TOPM && !rBusyN) || (lr && lAddr == TOPM && !lBusyN);
    bR = (lw && lAddr == TOP && !lBusyN) || (rr && rAddr == TOP && !rBusyN);
    if (lw) mdl[lAddr] = lDin;
    if (rw) mdl[rAddr] = rDin;
    tL = (sL && cL) ? "R10" : sL ? "R6" : cL ? "R7" : bL ? "R8" : "R9";
    tR = (sR && cR) ? "R10" : sR ? "R4" : cR ? "R5" : bR ? "R8" : "R9";
    flagL = nextFlag(flagL, sL, cL);
    flagR = nextFlag(flagR, sR, cR);
    @(negedge clk);
    chk(dL, "lDout", lDout, expL);
    chk(dR, "rDout", rDout, expR);
    chk(tL, "lIntN", {{(DW-1){1'b0}}, lIntN}, {{(DW-1){1'b0}}, ~flagL});
    chk(tR, "rIntN", {{(DW-1){1'b0}}, rIntN}, {{(DW-1){1'b0}}, ~flagR});
  endtask

  function automatic logic [AW-1:0] pickAddr(int unsigned r);
    return (r % 10 < 2) ? TOP : (r % 10 < 4) ? TOPM : AW'(r % 8);
  endfunction

  initial begin
    int unsigned seed = 32'h5EED_1234;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1", "lIntN", {{(DW-1){1'b0}}, lIntN}, {{(DW-1){1'b0}}, 1'b1});
    chk("R1", "rIntN", {{(DW-1){1'b0}}, rIntN}, {{(DW-1){1'b0}}, 1'b1});
    chk("R1", "lDout", lDout, '0);
    chk("R1", "rDout", rDout, '0);

    // Fill the address pool; left to own inbox (R9) and left to top (R4)
    for (int i = 0; i < 8; i++) begin
      setL(0, 0, 1, AW'(i), DW'($urandom), 1); setR(1, 1, 1, '0, '0, 1); step();
    end
    setL(0, 0, 1, TOPM, 18'h1A5A5, 1); step();
    setL(0, 0, 1, TOP, 18'h2C3C3, 1); step();
    setL(1, 1, 1, '0, '0, 1); step();
    // Right reads top: clears right flag and returns word (R5, R11)
    setR(0, 1, 0, TOP, '0, 1); step();
    // Right writes own inbox (top): no flag change (R9)
    setR(0, 0, 1, TOP, 18'h0BEEF, 1); step();
    // Right writes left inbox with busy low: stored, no flag (R8)
    setR(0, 0, 1, TOPM, 18'h11111, 0); step();
    setR(1, 1, 1, '0, '0, 1); setL(0, 1, 0, TOPM, '0, 1); step();
    // Right sets left flag (R6), left reads with busy low (R8), then clears (R7)
    setL(1, 1, 1, '0, '0, 1); setR(0, 0, 1, TOPM, 18'h22222, 1); step();
    setR(1, 1, 1, '0, '0, 1); setL(0, 1, 0, TOPM, '0, 0); step();
    setL(0, 1, 0, TOPM, '0, 1); step();
    // Set and clear on the same edge: set wins (R10)
    setL(0, 0, 1, TOP, 18'h33333, 1); setR(0, 1, 0, TOP, '0, 1); step();
    setL(1, 1, 1, '0, '0, 1); setR(1, 1, 1, '0, '0, 1); step();

    for (int n = 0; n < 3000; n++) begin
      logic [AW-1:0] la, ra;
      logic lce, lwe, rce, rwe;
      la = pickAddr($urandom); ra = pickAddr($urandom);
      lce = ($urandom % 5) == 0; rce = ($urandom % 5) == 0;
      lwe = $urandom; rwe = $urandom;
      if (!lce && !rce && la == ra && (!lwe || !rwe)) rce = 1;
      setL(lce, lwe, $urandom % 4 == 0, la, DW'($urandom), $urandom % 5 != 0);
      setR(rce, rwe, $urandom % 4 == 0, ra, DW'($urandom), $urandom % 5 != 0);
      step();
    end

    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #200us;
    if (!finished) begin
      finished = 1;
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule